// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block gives a host on a byte-wide I/O bus access to a small set of configuration registers through two adjacent port addresses: an index port and a data port. Out of reset the pair is locked. Writing a fixed four-byte key to the index port opens configuration mode. After that, a byte written to the index port chooses a register, and the data port reads or writes the chosen register.

Register 0x07 selects a logical device number. The activate and base-address registers seen at the banked indices belong to whichever device that number names. Three devices are implemented, at numbers 0x07, 0x09 and 0x0A. Each one holds a one-bit activate flag and a 16-bit base address. A read-only chip identifier and revision sit at fixed indices. Writing index 0x02 and then the value 0x02 to the data port leaves configuration mode and locks the pair again.

The bus is modelled as single-cycle read and write strobes with a 16-bit address. Read data is combinational from the address and the current state.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is locked, both ports read 0xFF, and once unlocked the device select register (index 0x07) reads 0x00.
- R2: Configuration mode opens on the write that completes the sequence 0x87, 0x01, 0x55, 0x55 to the index port (0x2E), and not before it. While unlocked, an index port read returns the last index written, which is 0x00 after each unlock.
- R3: A key byte that does not match the next expected byte restarts matching. If that wrong byte is 0x87, it counts as the first key byte of a new attempt.
- R4: While locked, data port (0x2F) reads return 0xFF and data port writes change no register.
- R5: Writing 0x02 to the data port while the index is 0x02 locks the block. Any other value written at index 0x02 leaves it unlocked.
- R6: Index 0x07 is a read/write device select, and its value is kept across lock and unlock.
- R7: Indices 0x20 and 0x21 read the high and low bytes of the chip identifier (default 0xA5C3). Index 0x22 reads the revision in bits 3:0 (default 6) with bits 7:4 zero. Writes to these indices have no effect.
- R8: For the selected device, index 0x30 bit 0 is the activate flag (bits 7:1 read 0), and indices 0x60 and 0x61 are the high and low base-address bytes. The three devices keep separate values.
- R9: Unimplemented indices read 0x00. Banked indices read 0x00 and ignore writes when the select register names no implemented device.
- R10: Writes and reads at addresses other than 0x2E and 0x2F affect nothing, including key matching, and such reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational; 0xFF when not driven |

## Verification
The bench targets key-matching corner cases. One case feeds a wrong byte partway through the key. A matcher that fails to restart would unlock on the wrong sequence. Another case makes 0x87 the wrong byte. A matcher that fails to resynchronise would stay locked after a valid key that follows it.

The bench also checks that data writes made while locked leave the registers untouched. A design that does not gate them would corrupt the select register. The exit sequence is tried with a wrong value first, so a design that locks on any write to index 0x02 is caught.

Banked values are written to all three devices and read back after switching the select. Shared or aliased storage would show up as cross-talk between devices. Writes made while no device is selected must not reach any bank.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int KEY_LEN = 4;
  localparam int NUM_DEV = 3;

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VALUE  = 8'h02;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  // Unlock key, in the order it must arrive.
  function automatic logic [7:0] key_byte(input int pos);
    case (pos)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

  // Device number of each implemented bank.
  function automatic logic [7:0] dev_num(input int slot);
    case (slot)
      0:       dev_num = 8'h07;
      1:       dev_num = 8'h09;
      default: dev_num = 8'h0A;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_keymatch.sv
module cfgport_keymatch
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr_i,
  input  logic [7:0] key_byte_i,
  input  logic       lock_req_i,
  output logic       unlocked_o
);

  localparam int PTR_W = $clog2(KEY_LEN);

  logic [PTR_W-1:0] pos_q, pos_d;
  logic             unl_q, unl_d;
  logic             en;

  assign en = lock_req_i | (~unl_q & key_wr_i);

  always_comb begin
    pos_d = pos_q;
    unl_d = unl_q;
    if (lock_req_i) begin
      unl_d = 1'b0;
      pos_d = '0;
    end else if (!unl_q && key_wr_i) begin
      if (key_byte_i == key_byte(int'(pos_q))) begin
        if (pos_q == PTR_W'(KEY_LEN - 1)) begin
          unl_d = 1'b1;
          pos_d = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else if (key_byte_i == key_byte(0)) begin
        pos_d = PTR_W'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      unl_q <= 1'b0;
    end else if (en) begin
      pos_q <= pos_d;
      unl_q <= unl_d;
    end
  end

  assign unlocked_o = unl_q;

  // R2: unlocking only ever follows a write of the final key byte
  assert_unlock_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(key_wr_i && key_byte_i == key_byte(KEY_LEN - 1)));

  // R3: a key write while locked that is not a full match keeps the lock
  assert_partial_key_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && key_wr_i && key_byte_i != key_byte(KEY_LEN - 1)) |=> !unl_q);

endmodule

// File: rtl/cfgport_global.sv
module cfgport_global
  import cfgport_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] devsel_o,
  output logic [7:0] rdata_o
);

  logic [7:0] sel_q;
  logic       sel_en;

  assign sel_en = wr_i & (idx_i == IDX_DEVSEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= wdata_i;
  end

  always_comb begin
    case (idx_i)
      IDX_DEVSEL: rdata_o = sel_q;
      IDX_ID_HI:  rdata_o = CHIP_ID[15:8];
      IDX_ID_LO:  rdata_o = CHIP_ID[7:0];
      IDX_REV:    rdata_o = {4'h0, CHIP_REV};
      default:    rdata_o = 8'h00;
    endcase
  end

  assign devsel_o = sel_q;

  // R6: the select register only moves on a write addressed to it
  assert_devsel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && idx_i == IDX_DEVSEL) |=> $stable(sel_q));

endmodule

// File: rtl/cfgport_ldev.sv
module cfgport_ldev
  import cfgport_pkg::*;
#(
  parameter logic [7:0] DEV_NUM = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] devsel_i,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);

  logic        sel;
  logic        act_q;
  logic [15:0] base_q;
  logic        act_en, hi_en, lo_en;

  assign sel    = (devsel_i == DEV_NUM);
  assign act_en = wr_i & sel & (idx_i == IDX_ACT);
  assign hi_en  = wr_i & sel & (idx_i == IDX_BASE_HI);
  assign lo_en  = wr_i & sel & (idx_i == IDX_BASE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q[15:8] <= '0;
    else if (hi_en) base_q[15:8] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q[7:0] <= '0;
    else if (lo_en) base_q[7:0] <= wdata_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel) begin
      case (idx_i)
        IDX_ACT:     rdata_o = {7'h00, act_q};
        IDX_BASE_HI: rdata_o = base_q[15:8];
        IDX_BASE_LO: rdata_o = base_q[7:0];
        default:     rdata_o = 8'h00;
      endcase
    end
  end

  // R8: a bank keeps its contents while another device is selected
  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(base_q) && $stable(act_q)));

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0]     CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]      CHIP_REV   = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic       at_index, at_data;
  logic       unlocked;
  logic       key_wr, lock_req, cfg_wr, idx_en;
  logic [7:0] idx_q, idx_d;
  logic [7:0] devsel;
  logic [7:0] glob_rdata, cfg_rdata;
  logic [7:0] dev_rdata [NUM_DEV];

  assign at_index = (io_addr == INDEX_ADDR);
  assign at_data  = (io_addr == DATA_ADDR);
  assign key_wr   = io_wr & at_index;
  assign cfg_wr   = unlocked & io_wr & at_data;
  assign lock_req = cfg_wr & (idx_q == IDX_EXIT) & (io_wdata == EXIT_VALUE);
  assign idx_en   = (unlocked & io_wr & at_index) | lock_req;

  always_comb begin
    idx_d = io_wdata;
    if (lock_req) idx_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  cfgport_keymatch u_keymatch (
    .clk        (clk),
    .rst_n      (rst_ns),
    .key_wr_i   (key_wr),
    .key_byte_i (io_wdata),
    .lock_req_i (lock_req),
    .unlocked_o (unlocked)
  );

  cfgport_global #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_global (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_i     (cfg_wr),
    .idx_i    (idx_q),
    .wdata_i  (io_wdata),
    .devsel_o (devsel),
    .rdata_o  (glob_rdata)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    cfgport_ldev #(
      .DEV_NUM (dev_num(g))
    ) u_ldev (
      .clk      (clk),
      .rst_n    (rst_ns),
      .devsel_i (devsel),
      .wr_i     (cfg_wr),
      .idx_i    (idx_q),
      .wdata_i  (io_wdata),
      .rdata_o  (dev_rdata[g])
    );
  end

  always_comb begin
    cfg_rdata = glob_rdata;
    for (int i = 0; i < NUM_DEV; i++) cfg_rdata = cfg_rdata | dev_rdata[i];
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && unlocked) begin
      if (at_index)     io_rdata = idx_q;
      else if (at_data) io_rdata = cfg_rdata;
    end
  end

  // R5: the exit write locks the pair on the next cycle
  assert_exit_locks_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    lock_req |=> !unlocked);

  // R4: nothing written through the data port while locked reaches the select
  assert_locked_no_write_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    !unlocked |=> $stable(devsel));

  // R10: accesses elsewhere on the bus leave the index untouched
  assert_foreign_addr_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (!at_index && !at_data) |=> $stable(idx_q));

endmodule

// File: tb/cfgport_ctrl_bench.sv
module cfgport_ctrl_bench;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cfgport_ctrl u_cfgport_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic send_key();
    bus_wr(IDX, 8'h87); bus_wr(IDX, 8'h01);
    bus_wr(IDX, 8'h55); bus_wr(IDX, 8'h55);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    bus_wr(IDX, i); bus_wr(DAT, v);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    bus_wr(IDX, i); bus_rd(DAT, v);
  endtask

  task automatic leave();
    reg_wr(8'h02, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(DAT, v); check("R1 data locked", v, 8'hFF);
    bus_rd(IDX, v); check("R1 index locked", v, 8'hFF);
    send_key();
    reg_rd(8'h07, v); check("R1 select reset", v, 8'h00);
    leave();
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    bus_wr(IDX, 8'h87); bus_wr(IDX, 8'h01); bus_wr(IDX, 8'h55);
    bus_rd(IDX, v); check("R2 three bytes locked", v, 8'hFF);
    bus_wr(IDX, 8'h55);
    bus_rd(IDX, v); check("R2 unlocked index", v, 8'h00);
    leave();
  endtask

  task automatic t_restart();
    logic [7:0] v;
    bus_wr(IDX, 8'h87); bus_wr(IDX, 8'h01); bus_wr(IDX, 8'h33);
    bus_wr(IDX, 8'h55); bus_wr(IDX, 8'h55);
    bus_rd(IDX, v); check("R3 wrong byte restarts", v, 8'hFF);
    bus_wr(IDX, 8'h87); bus_wr(IDX, 8'h01); bus_wr(IDX, 8'h87);
    bus_wr(IDX, 8'h01); bus_wr(IDX, 8'h55); bus_wr(IDX, 8'h55);
    bus_rd(IDX, v); check("R3 87 resyncs late", v, 8'h00);
    leave();
    bus_wr(IDX, 8'h87); send_key();
    bus_rd(IDX, v); check("R3 87 resyncs early", v, 8'h00);
    leave();
  endtask

  task automatic t_locked();
    logic [7:0] v;
    bus_wr(IDX, 8'h07); bus_wr(DAT, 8'h09);
    bus_rd(DAT, v); check("R4 locked data read", v, 8'hFF);
    send_key();
    reg_rd(8'h07, v); check("R4 locked write ignored", v, 8'h00);
    leave();
  endtask

  task automatic t_exit();
    logic [7:0] v;
    send_key();
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h02, 8'h01);
    bus_rd(IDX, v); check("R5 wrong exit value", v, 8'h02);
    bus_wr(IDX, 8'h22);
    bus_rd(IDX, v); check("R2 index readback", v, 8'h22);
    leave();
    bus_rd(IDX, v); check("R5 locked after exit", v, 8'hFF);
    send_key();
    reg_rd(8'h07, v); check("R6 select kept", v, 8'h09);
    reg_wr(8'h07, 8'h0A);
    reg_rd(8'h07, v); check("R6 select written", v, 8'h0A);
    leave();
  endtask

  task automatic t_ids();
    logic [7:0] v;
    send_key();
    reg_rd(8'h20, v); check("R7 id high", v, 8'hA5);
    reg_rd(8'h21, v); check("R7 id low", v, 8'hC3);
    reg_rd(8'h22, v); check("R7 revision", v, 8'h06);
    reg_wr(8'h20, 8'h00);
    reg_rd(8'h20, v); check("R7 id read-only", v, 8'hA5);
    leave();
  endtask

  task automatic t_banks();
    logic [7:0] v;
    send_key();
    reg_wr(8'h07, 8'h07); reg_wr(8'h30, 8'hFF);
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    reg_wr(8'h07, 8'h09); reg_wr(8'h30, 8'h00);
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'h01);
    reg_wr(8'h07, 8'h0A); reg_wr(8'h30, 8'h01);
    reg_wr(8'h60, 8'hAB); reg_wr(8'h61, 8'hCD);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h30, v); check("R8 dev07 act", v, 8'h01);
    reg_rd(8'h60, v); check("R8 dev07 base hi", v, 8'h12);
    reg_rd(8'h61, v); check("R8 dev07 base lo", v, 8'h34);
    reg_wr(8'h07, 8'h09);
    reg_rd(8'h30, v); check("R8 dev09 act", v, 8'h00);
    reg_rd(8'h60, v); check("R8 dev09 base hi", v, 8'h02);
    reg_rd(8'h61, v); check("R8 dev09 base lo", v, 8'h01);
    reg_wr(8'h07, 8'h0A);
    reg_rd(8'h30, v); check("R8 dev0A act", v, 8'h01);
    reg_rd(8'h60, v); check("R8 dev0A base hi", v, 8'hAB);
    reg_rd(8'h61, v); check("R8 dev0A base lo", v, 8'hCD);
    leave();
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    send_key();
    reg_rd(8'h55, v); check("R9 unimplemented index", v, 8'h00);
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h60, v); check("R9 no device read", v, 8'h00);
    reg_wr(8'h60, 8'h77);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h60, v); check("R9 no device write", v, 8'h12);
    leave();
  endtask

  task automatic t_other();
    logic [7:0] v;
    bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h01);
    bus_wr(16'h004E, 8'h55); bus_wr(16'h004E, 8'h55);
    bus_rd(IDX, v); check("R10 key elsewhere", v, 8'hFF);
    send_key();
    bus_wr(IDX, 8'h60);
    bus_wr(16'h002D, 8'h61); bus_wr(16'h0030, 8'h99);
    bus_rd(DAT, v); check("R10 index kept", v, 8'h12);
    bus_rd(16'h0030, v); check("R10 foreign read", v, 8'hFF);
    leave();
  endtask

  initial begin
    io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unlock();
    t_restart();
    t_locked();
    t_exit();
    t_ids();
    t_banks();
    t_unimpl();
    t_other();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule